// File: doc/BRIEF.md
# Scaled Perceptron Prediction Datapath

This block produces a taken or not-taken verdict for a single branch from a perceptron-style dot product. It receives 128 signed correlating weights and one bias weight, already read from weight tables, together with a 128-bit expanded history vector. Each correlating weight is stored as a 7-bit sign-magnitude value. Its magnitude is weighted bit by bit with coefficients that decline with history position, so older history contributes less. The scaled magnitude then goes into one of two running totals, a positive one or a negative one. Which total it joins depends on the weight's sign and the matching history bit.

The block works through the correlating weights eight at a time, one group per clock, taking sixteen clocks for the full set. A final clock folds in the bias weight and makes three comparisons of the two totals at the same time. The first gives the prediction. The other two are margin hints that tell the training logic whether the result cleared a programmable threshold in either direction. A caller pulses `start`, holds all data inputs steady, and reads the three result bits when `valid` pulses.

Top module: `scaled_perceptron_core`

## Requirements
- R1: While reset is asserted, `valid`, `pred`, `hint_t` and `hint_n` are all 0.
- R2: A `start` pulse sampled while the block is idle makes `valid` high for exactly one cycle, 17 clock edges later (16 accumulation edges plus one finishing edge). `valid` is never high at any other time.
- R3: A `start` sampled while a computation is in progress is ignored. The running computation keeps its timing, and no extra `valid` pulse follows.
- R4: Position p (1..128) reads its weight from `weights[7(p-1)+6 : 7(p-1)]`. Bit 6 of that field is the sign (1 = negative) and bits 5:0 are the magnitude. Its history bit is `hist[p-1]`. The scaled magnitude joins the positive total when (sign XOR history bit) is 1, and the negative total otherwise.
- R5: Magnitude bit b of position p contributes coef(p,b) when it is set. The coefficient is the rounded linear interpolation between two anchor rows: position 3 uses (1,1,3,5,11,21) and position 128 uses (0,1,1,2,4,8), for bits 0..5. The formula is coef = (A3·(128−p) + A128·(p−3) + 62) / 125, using integer division. It gives exactly (1,1,3,5,11,21) at p=3 and (0,1,1,2,4,8) at p=128.
- R6: The bias weight (`bias`, bit 6 = sign, bits 5:0 = magnitude) is added unscaled. Its magnitude goes to the positive total when the sign is 0 and to the negative total when the sign is 1.
- R7: `pred` is 1 exactly when the positive total is strictly greater than the negative total. Equal totals give 0.
- R8: `hint_t` is 1 exactly when the positive total is strictly greater than the negative total plus `thresh`.
- R9: `hint_n` is 1 exactly when the positive total plus `thresh` is strictly greater than the negative total.
- R10: `pred`, `hint_t` and `hint_n` keep their last result between `valid` pulses, whatever the inputs do.
- R11: The totals never overflow. Even with every magnitude at 63 and every term on the same side, all three result bits are correct.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| start | input | 1 | Begins one prediction when the block is idle |
| weights | input | 896 | 128 sign-magnitude correlating weights, 7 bits each, position 1 in the lowest bits |
| bias | input | 7 | Sign-magnitude bias weight |
| hist | input | 128 | Expanded history, bit p-1 belongs to position p, 1 = taken |
| thresh | input | 8 | Unsigned training threshold |
| valid | output | 1 | One-cycle pulse marking a new result |
| pred | output | 1 | Prediction, 1 = taken |
| hint_t | output | 1 | Positive total exceeds negative total plus threshold |
| hint_n | output | 1 | Positive total plus threshold exceeds negative total |

## Verification
A wrong coefficient, a swapped steering sense or a row counter that skips a group leaves no trace until the finishing edge. It then shows as a wrong `pred` or hint bit on the single `valid` cycle, 17 edges after `start`. This is why each directed case isolates one position or the bias, so that a fault moves a total across the zero or threshold boundary. A corrupted control state instead shows as a `valid` pulse that comes early, comes late, is missing or repeats. Every cycle is compared against a behavioural model, so such a fault is caught on the first cycle it occurs.

// File: rtl/np_pkg.sv
package np_pkg;

  localparam int W_BITS = 7;
  localparam int MAG_W  = 6;
  localparam int COEF_W = 6;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ACC  = 2'd1,
    ST_FIN  = 2'd2
  } np_state_e;

  // Rounded linear blend between the near anchor (position 3) and the
  // far anchor (position npos) for magnitude bit bitn.
  function automatic int scale_coef(input int pos, input int bitn, input int npos);
    int near_v;
    int far_v;
    int den;
    int num;
    case (bitn)
      0:       begin near_v = 1;  far_v = 0; end
      1:       begin near_v = 1;  far_v = 1; end
      2:       begin near_v = 3;  far_v = 1; end
      3:       begin near_v = 5;  far_v = 2; end
      4:       begin near_v = 11; far_v = 4; end
      default: begin near_v = 21; far_v = 8; end
    endcase
    den = npos - 3;
    if (den < 1) return near_v;
    num = near_v * (npos - pos) + far_v * (pos - 3) + den / 2;
    if (num < 0) num = 0;
    return num / den;
  endfunction

endpackage

// File: rtl/np_lane.sv
module np_lane #(
  parameter int LANE   = 0,
  parameter int LANES  = 8,
  parameter int NPOS   = 128,
  parameter int SUM_W  = 9,
  localparam int ROWS  = NPOS / LANES,
  localparam int ROW_W = $clog2(ROWS)
) (
  input  logic [ROW_W-1:0]         row,
  input  logic [np_pkg::W_BITS-1:0] weight,
  input  logic                     hbit,
  output logic [SUM_W-1:0]         pos_add,
  output logic [SUM_W-1:0]         neg_add
);
  import np_pkg::*;

  logic [COEF_W-1:0] coef [ROWS][MAG_W];
  logic [SUM_W-1:0]  scaled;

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    for (genvar b = 0; b < MAG_W; b++) begin : g_bit
      localparam int CV = scale_coef(r * LANES + LANE + 1, b, NPOS);
      assign coef[r][b] = CV[COEF_W-1:0];
    end
  end

  always_comb begin
    scaled = '0;
    for (int b = 0; b < MAG_W; b++) begin
      if (weight[b]) scaled = scaled + SUM_W'(coef[row][b]);
    end
  end

  // sign XOR history selects the positive side
  always_comb begin
    if (weight[W_BITS-1] ^ hbit) begin
      pos_add = scaled;
      neg_add = '0;
    end else begin
      pos_add = '0;
      neg_add = scaled;
    end
  end

endmodule

// File: rtl/np_finish.sv
module np_finish #(
  parameter int ACC_W = 14,
  parameter int THR_W = 8,
  localparam int EXT_W = ACC_W + 1
) (
  input  logic [ACC_W-1:0]          pos_acc,
  input  logic [ACC_W-1:0]          neg_acc,
  input  logic [np_pkg::W_BITS-1:0] bias,
  input  logic [THR_W-1:0]          thr,
  output logic                      pred,
  output logic                      over_t,
  output logic                      over_n
);
  import np_pkg::*;

  logic [EXT_W-1:0] pos_f;
  logic [EXT_W-1:0] neg_f;
  logic [EXT_W-1:0] bias_mag;
  logic [EXT_W-1:0] thr_x;

  always_comb begin
    bias_mag = EXT_W'(bias[MAG_W-1:0]);
    thr_x    = EXT_W'(thr);
    pos_f    = EXT_W'(pos_acc) + (bias[W_BITS-1] ? '0 : bias_mag);
    neg_f    = EXT_W'(neg_acc) + (bias[W_BITS-1] ? bias_mag : '0);
    // three independent comparisons on the same totals
    pred     = pos_f > neg_f;
    over_t   = pos_f > (neg_f + thr_x);
    over_n   = (pos_f + thr_x) > neg_f;
  end

endmodule

// File: rtl/scaled_perceptron_core.sv
module scaled_perceptron_core #(
  parameter int NPOS  = 128,
  parameter int LANES = 8,
  parameter int THR_W = 8
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             start,
  input  logic [NPOS*np_pkg::W_BITS-1:0]   weights,
  input  logic [np_pkg::W_BITS-1:0]        bias,
  input  logic [NPOS-1:0]                  hist,
  input  logic [THR_W-1:0]                 thresh,
  output logic                             valid,
  output logic                             pred,
  output logic                             hint_t,
  output logic                             hint_n
);
  import np_pkg::*;

  localparam int ROWS   = NPOS / LANES;
  localparam int ROW_W  = $clog2(ROWS);
  localparam int MAXMAG = (1 << MAG_W) - 1;
  localparam int LSUM_W = $clog2(MAXMAG * LANES + 1);
  localparam int ACC_W  = $clog2(MAXMAG * (NPOS + 1) + 1) + 1;

  // reset: asserted asynchronously, released through two flops
  logic [1:0] rst_sync_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sync_n = rst_sync_q[1];

  np_state_e         state_q, state_d;
  logic [ROW_W-1:0]  row_q, row_d;
  logic [ACC_W-1:0]  pos_q, pos_d, neg_q, neg_d;
  logic              valid_q, valid_d;
  logic              pred_q, pred_d, t_q, t_d, n_q, n_d;

  logic [LSUM_W-1:0] lane_pos [LANES];
  logic [LSUM_W-1:0] lane_neg [LANES];
  logic [ACC_W-1:0]  row_pos, row_neg;
  logic              fin_pred, fin_t, fin_n;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [W_BITS-1:0] sel_w;
    logic              sel_h;
    assign sel_w = weights[(int'(row_q) * LANES + l) * W_BITS +: W_BITS];
    assign sel_h = hist[int'(row_q) * LANES + l];

    np_lane #(
      .LANE (l),
      .LANES(LANES),
      .NPOS (NPOS),
      .SUM_W(LSUM_W)
    ) u_lane (
      .row    (row_q),
      .weight (sel_w),
      .hbit   (sel_h),
      .pos_add(lane_pos[l]),
      .neg_add(lane_neg[l])
    );
  end

  always_comb begin
    row_pos = '0;
    row_neg = '0;
    for (int l = 0; l < LANES; l++) begin
      row_pos = row_pos + ACC_W'(lane_pos[l]);
      row_neg = row_neg + ACC_W'(lane_neg[l]);
    end
  end

  np_finish #(
    .ACC_W(ACC_W),
    .THR_W(THR_W)
  ) u_finish (
    .pos_acc(pos_q),
    .neg_acc(neg_q),
    .bias   (bias),
    .thr    (thresh),
    .pred   (fin_pred),
    .over_t (fin_t),
    .over_n (fin_n)
  );

  // next-state logic
  always_comb begin
    state_d = state_q;
    row_d   = row_q;
    pos_d   = pos_q;
    neg_d   = neg_q;
    valid_d = 1'b0;
    pred_d  = pred_q;
    t_d     = t_q;
    n_d     = n_q;
    case (state_q)
      ST_IDLE: begin
        if (start) begin
          state_d = ST_ACC;
          row_d   = '0;
          pos_d   = '0;
          neg_d   = '0;
        end
      end
      ST_ACC: begin
        pos_d = pos_q + row_pos;
        neg_d = neg_q + row_neg;
        row_d = ROW_W'(row_q + 1'b1);
        if (row_q == ROW_W'(ROWS - 1)) state_d = ST_FIN;
      end
      ST_FIN: begin
        valid_d = 1'b1;
        pred_d  = fin_pred;
        t_d     = fin_t;
        n_d     = fin_n;
        state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  logic acc_en;
  logic res_en;
  assign acc_en = (state_q != ST_IDLE) || start;
  assign res_en = (state_q == ST_FIN);

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      state_q <= ST_IDLE;
      row_q   <= '0;
      pos_q   <= '0;
      neg_q   <= '0;
      valid_q <= 1'b0;
      pred_q  <= 1'b0;
      t_q     <= 1'b0;
      n_q     <= 1'b0;
    end else begin
      state_q <= state_d;
      valid_q <= valid_d;
      if (acc_en) begin
        row_q <= row_d;
        pos_q <= pos_d;
        neg_q <= neg_d;
      end
      if (res_en) begin
        pred_q <= pred_d;
        t_q    <= t_d;
        n_q    <= n_d;
      end
    end
  end

  assign valid  = valid_q;
  assign pred   = pred_q;
  assign hint_t = t_q;
  assign hint_n = n_q;

endmodule

// File: rtl/np_checker.sv
module np_checker #(
  parameter int ROWS = 16,
  localparam int CNT_W = $clog2(ROWS + 2) + 1
) (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic valid,
  input logic pred,
  input logic hint_t,
  input logic hint_n
);

  logic             busy_q;
  logic [CNT_W-1:0] cnt_q;
  logic             due_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      due_q  <= 1'b0;
    end else begin
      due_q <= busy_q && (cnt_q == CNT_W'(ROWS));
      if (busy_q) begin
        cnt_q <= cnt_q + 1'b1;
        if (cnt_q == CNT_W'(ROWS)) busy_q <= 1'b0;
      end else if (start) begin
        busy_q <= 1'b1;
        cnt_q  <= '0;
      end
    end
  end

  // R2 / R3: result appears only at the fixed latency of an accepted start
  assert_valid_on_time_R2: assert property (@(posedge clk) disable iff (!rst_n)
    due_q |-> valid);
  assert_no_stray_valid_R3: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> due_q);
  assert_single_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    valid |=> !valid);
  assert_t_implies_pred_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && hint_t) |-> pred);
  assert_pred_implies_n_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && pred) |-> hint_n);
  assert_hold_result_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !valid |-> $stable({pred, hint_t, hint_n}));

endmodule

bind scaled_perceptron_core np_checker #(.ROWS(NPOS / LANES)) u_np_checker (
  .clk   (clk),
  .rst_n (rst_sync_n),
  .start (start),
  .valid (valid),
  .pred  (pred),
  .hint_t(hint_t),
  .hint_n(hint_n)
);

// File: tb/scaled_perceptron_core_tb.sv
`timescale 1ns/1ps
module scaled_perceptron_core_tb_top;

  localparam int NPOS = 128;
  localparam int LAT  = 17;

  logic              clk;
  logic              rst_n;
  logic              start;
  logic [NPOS*7-1:0] weights;
  logic [6:0]        bias;
  logic [NPOS-1:0]   hist;
  logic [7:0]        thresh;
  logic              valid, pred, hint_t, hint_n;

  int checks   = 0;
  int failures = 0;
  int cycles   = 0;

  // behavioural model state
  bit m_busy = 0;
  int m_cnt  = 0;
  bit e_valid = 0, e_pred = 0, e_t = 0, e_n = 0;
  string tname = "reset";

  scaled_perceptron_core dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .weights(weights), .bias(bias),
    .hist(hist), .thresh(thresh), .valid(valid), .pred(pred),
    .hint_t(hint_t), .hint_n(hint_n)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic int coef(int p, int b);
    int near_row[6] = '{1, 1, 3, 5, 11, 21};
    int far_row[6]  = '{0, 1, 1, 2, 4, 8};
    return (near_row[b] * (128 - p) + far_row[b] * (p - 3) + 62) / 125;
  endfunction

  task automatic reference(output bit rp, output bit rt, output bit rn);
    int sp = 0, sn = 0;
    for (int p = 1; p <= NPOS; p++) begin
      logic [6:0] w;
      int mag = 0;
      w = weights[(p-1)*7 +: 7];
      for (int b = 0; b < 6; b++) if (w[b]) mag += coef(p, b);
      if (w[6] != hist[p-1]) sp += mag; else sn += mag;
    end
    if (bias[6]) sn += int'(bias[5:0]); else sp += int'(bias[5:0]);
    rp = sp > sn;
    rt = sp > sn + int'(thresh);
    rn = sp + int'(thresh) > sn;
  endtask

  task automatic chk(string req, bit act, bit exp_v);
    checks++;
    if (act !== exp_v) begin
      failures++;
      $display("FAIL %s [%s] actual=%0b expected=%0b", req, tname, act, exp_v);
    end
  endtask

  task automatic tick();
    bit nv = 0;
    bit rp, rt, rn;
    if (m_busy) begin
      m_cnt++;
      if (m_cnt == LAT) begin
        reference(rp, rt, rn);
        nv = 1; m_busy = 0;
        e_pred = rp; e_t = rt; e_n = rn;
      end
    end else if (start) begin
      m_busy = 1; m_cnt = 0;
    end
    @(posedge clk);
    @(negedge clk);
    e_valid = nv;
    chk("R2 valid", valid, e_valid);
    if (e_valid) begin
      chk("R7 pred", pred, e_pred);
      chk("R8 hint_t", hint_t, e_t);
      chk("R9 hint_n", hint_n, e_n);
    end else begin
      chk("R10 hold pred", pred, e_pred);
      chk("R10 hold hint_t", hint_t, e_t);
      chk("R10 hold hint_n", hint_n, e_n);
    end
  endtask

  task automatic clear_inputs();
    weights = '0; bias = '0; hist = '0; thresh = '0;
  endtask

  task automatic set_w(int p, bit s, int mag, bit h);
    weights[(p-1)*7 +: 7] = {s, 6'(mag)};
    hist[p-1] = h;
  endtask

  task automatic run(string name);
    tname = name;
    start = 1'b1;
    tick();
    start = 1'b0;
    for (int i = 0; i < LAT + 2; i++) tick();
  endtask

  initial begin
    rst_n = 1'b0; start = 1'b0;
    clear_inputs();
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 valid", valid, 1'b0);
    chk("R1 pred", pred, 1'b0);
    chk("R1 hint_t", hint_t, 1'b0);
    chk("R1 hint_n", hint_n, 1'b0);
    rst_n = 1'b1;
    for (int i = 0; i < 4; i++) tick();

    // R7 tie: all zero totals
    run("R7 zero totals");

    // R5 anchor rows: position 3 positive (42), position 128 negative (16)
    clear_inputs();
    set_w(3, 1'b0, 63, 1'b1);
    set_w(128, 1'b0, 63, 1'b0);
    thresh = 8'd20;
    run("R5 anchors thr20");
    thresh = 8'd30;
    run("R5 anchors thr30 R8 margin");

    // R4 steering: negative sign with not-taken history lands positive
    clear_inputs();
    set_w(40, 1'b1, 37, 1'b0);
    thresh = 8'd3;
    run("R4 sign xor history");
    set_w(40, 1'b1, 37, 1'b1);
    run("R4 same sign same history");

    // R6 bias alone, unscaled
    clear_inputs();
    bias = 7'h05; thresh = 8'd5;
    run("R6 bias positive");
    bias = 7'h45; thresh = 8'd4;
    run("R6 bias negative R9");
    bias = 7'h45; thresh = 8'd6;
    run("R6 bias negative thr6 R9");

    // R11 all magnitudes maximal on one side
    clear_inputs();
    for (int p = 1; p <= NPOS; p++) set_w(p, 1'b0, 63, 1'b1);
    bias = 7'h3F; thresh = 8'hFF;
    run("R11 all positive max");
    for (int p = 1; p <= NPOS; p++) set_w(p, 1'b0, 63, 1'b0);
    bias = 7'h7F;
    run("R11 all negative max");

    // R3 second start during a computation
    clear_inputs();
    set_w(1, 1'b0, 9, 1'b1);
    tname = "R3 restart ignored";
    start = 1'b1; tick();
    start = 1'b0;
    for (int i = 0; i < 5; i++) tick();
    start = 1'b1; tick();
    start = 1'b0;
    for (int i = 0; i < LAT + 4; i++) tick();

    // R10 inputs change with no start: results must hold
    tname = "R10 input churn";
    set_w(1, 1'b1, 9, 1'b1);
    bias = 7'h7F;
    for (int i = 0; i < 6; i++) tick();

    // mixed patterns, back-to-back starts
    for (int k = 0; k < 12; k++) begin
      for (int p = 1; p <= NPOS; p++) weights[(p-1)*7 +: 7] = 7'($urandom);
      hist   = {$urandom, $urandom, $urandom, $urandom};
      bias   = 7'($urandom);
      thresh = 8'($urandom_range(0, 60));
      tname = "mixed R4 R5";
      start = 1'b1; tick();
      start = 1'b0;
      for (int i = 0; i < LAT; i++) tick();
    end
    for (int i = 0; i < 3; i++) tick();

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      failures++;
      $display("FAIL R2 watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule